// File: doc/BRIEF.md
# Boot Image Header Validator

This block checks a 320-byte boot image header as it is streamed in, one byte per strobe, starting at byte 0. A start pulse opens a new header. Each byte is checked as soon as it arrives. The first rule that fails is kept as the reason for rejection. While the bytes stream past, the block captures the multi-byte little-endian fields and three single configuration bytes. It also decodes the loader-flag bits that a boot sequencer needs.

The verdict appears the cycle after the final byte is accepted. It stays in place, together with every captured field, until the next start pulse. A start pulse that arrives partway through a header throws away everything gathered so far and begins again at byte 0. No digest or signature work is done here.

Top module: `boot_hdr_validator`

## Requirements
- R1: After reset, `done_o`, `pass_o` and `reason_o` are 0, and every captured field output is 0.
- R2: A byte is accepted only while a header is open and `byte_vld_i` is high. A header opens on `start_i` and closes after its 320th accepted byte. A byte strobed in the same cycle as `start_i`, or while no header is open, is ignored.
- R3: `done_o` rises in the cycle after the 320th accepted byte. It stays high until the next `start_i`.
- R4: If bytes 0..3 are not 0x50, 0x48, 0x43, 0x4D in that order, the reason is 1 (bad identifier).
- R5: If byte 4 is not 0x03, the reason is 2 (bad version).
- R6: If the 16-bit little-endian unit count in bytes 0x10 (low) and 0x11 (high) is zero, the reason is 3 (empty payload).
- R7: The payload offset is the 32-bit little-endian value in bytes 0x14..0x17. If it is not a multiple of 128, the reason is 4 (misaligned offset).
- R8: If the payload offset is below 320, the reason is 5 (offset inside the header). An offset of 0x180 passes.
- R9: When several rules fail, the reason reported is the one whose deciding byte comes first in the stream. Identifier comes first, then version, then empty payload, then misaligned offset, then small offset. `pass_o` is 1 exactly when `done_o` is 1 and the reason is 0.
- R10: The load address (bytes 0x08..0x0B), the entry address (bytes 0x0C..0x0F), the unit count and the payload offset are each captured little-endian, with the lowest-addressed byte as the least significant byte.
- R11: Byte 5 is captured as the SPI configuration byte, byte 6 as the loader-flags byte and byte 7 as the read-command index. From byte 6: bit 0 gives `fast_clk_o`, bit 6 gives `auth_en_o` and bit 7 gives `encrypted_o`. `flags_fixed_ok_o` is 1 when bits 5:3 equal 111b. Flag values never affect the verdict.
- R12: A `start_i` clears `done_o`, `reason_o` and all captured fields in the next cycle, even in the middle of a header. The bytes that follow are taken from offset 0.
- R13: Once `done_o` is high, strobed bytes change neither the captured fields nor the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a new header at offset 0 |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Header byte |
| done_o | output | 1 | Verdict valid |
| pass_o | output | 1 | Header accepted |
| reason_o | output | 3 | Rejection reason, 0 when passed or not done |
| load_addr_o | output | 32 | Load address |
| entry_addr_o | output | 32 | Entry address |
| payload_units_o | output | 16 | Payload size in 128-byte units |
| payload_ofs_o | output | 32 | Offset from header start to payload |
| spi_cfg_o | output | 8 | SPI configuration byte |
| ldr_flags_o | output | 8 | Loader flags byte |
| read_cmd_o | output | 8 | Read-command index |
| fast_clk_o | output | 1 | 96 MHz override flag |
| auth_en_o | output | 1 | Authentication enable flag |
| encrypted_o | output | 1 | Encrypted payload flag |
| flags_fixed_ok_o | output | 1 | Loader flag bits 5:3 read 111b |

## Verification
The main check runs against a known-good header, and then against copies of it with one byte changed for each rule. Each single-fault copy shows that its rule maps to its own reason code. Copies with two faults show that streaming order, not code value, picks the reported reason. The payload offset is tried at 0x100, 0x141, 0x180 and a value with only its top byte set. These separate the too-small case, the misaligned case, the lowest legal value, and correct handling of the full 32-bit compare. Idle gaps in the strobe, a strobe coinciding with start, a restart partway through, and bytes sent after the verdict show that only strobed bytes inside an open header are counted.

// File: rtl/boot_hdr_pkg.sv
package boot_hdr_pkg;

  typedef enum logic [2:0] {
    RSN_NONE      = 3'd0,
    RSN_BAD_ID    = 3'd1,
    RSN_BAD_VER   = 3'd2,
    RSN_ZERO_SIZE = 3'd3,
    RSN_MISALIGN  = 3'd4,
    RSN_SMALL_OFS = 3'd5
  } reason_e;

  // identifier bytes 'P','H','C','M' packed little-endian
  localparam logic [31:0] ID_WORD = 32'h4D43_4850;

  localparam int unsigned POS_VER   = 4;
  localparam int unsigned POS_SPI   = 5;
  localparam int unsigned POS_FLAGS = 6;
  localparam int unsigned POS_RCMD  = 7;
  localparam int unsigned POS_LOAD  = 8;
  localparam int unsigned POS_ENTRY = 12;
  localparam int unsigned POS_UNITS = 16;
  localparam int unsigned POS_POFS  = 20;

endpackage

// File: rtl/boot_hdr_seq.sv
module boot_hdr_seq #(
  parameter int unsigned HDR_BYTES = 320,
  parameter int unsigned IDX_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             vld_i,
  output logic             accept_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BYTES - 1);

  logic             open_q, open_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             en;

  assign accept_o = open_q & vld_i & ~start_i;
  assign last_o   = accept_o & (idx_q == LAST_IDX);
  assign idx_o    = idx_q;
  assign en       = start_i | accept_o;

  always_comb begin
    open_d = open_q;
    idx_d  = idx_q;
    if (start_i) begin
      open_d = 1'b1;
      idx_d  = '0;
    end else if (accept_o) begin
      open_d = ~last_o;
      idx_d  = last_o ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      idx_q  <= '0;
    end else if (en) begin
      open_q <= open_d;
      idx_q  <= idx_d;
    end
  end

endmodule

// File: rtl/boot_hdr_lefield.sv
module boot_hdr_lefield #(
  parameter int unsigned BASE   = 8,
  parameter int unsigned NBYTES = 4,
  parameter int unsigned IDX_W  = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  accept_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [7:0]            byte_i,
  output logic [8*NBYTES-1:0]   value_o
);

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    localparam logic [IDX_W-1:0] LANE_IDX = IDX_W'(BASE + g);
    logic       en;
    logic [7:0] lane_d, lane_q;

    assign en     = clr_i | (accept_i & (idx_i == LANE_IDX));
    assign lane_d = clr_i ? 8'h00 : byte_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lane_q <= 8'h00;
      else if (en) lane_q <= lane_d;
    end

    assign value_o[8*g +: 8] = lane_q;
  end

endmodule

// File: rtl/boot_hdr_judge.sv
module boot_hdr_judge
  import boot_hdr_pkg::*;
#(
  parameter int unsigned HDR_BYTES = 320,
  parameter int unsigned UNIT_LOG2 = 7,
  parameter logic [7:0]  VERSION   = 8'h03,
  parameter int unsigned IDX_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             accept_i,
  input  logic             last_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  input  logic [7:0]       units_lo_i,
  input  logic [23:0]      pofs_lo_i,
  output logic             done_o,
  output logic             pass_o,
  output logic [2:0]       reason_o
);

  localparam logic [IDX_W-1:0] I_VER    = IDX_W'(POS_VER);
  localparam logic [IDX_W-1:0] I_UNITHI = IDX_W'(POS_UNITS + 1);
  localparam logic [IDX_W-1:0] I_POFS0  = IDX_W'(POS_POFS);
  localparam logic [IDX_W-1:0] I_POFS3  = IDX_W'(POS_POFS + 3);
  localparam logic [31:0]      MIN_OFS  = 32'(HDR_BYTES);

  reason_e hit;
  reason_e reason_q, reason_d;
  logic    fail_q, fail_d;
  logic    done_q, done_d;
  logic    en;

  always_comb begin
    hit = RSN_NONE;
    if (idx_i < IDX_W'(4)) begin
      if (byte_i != ID_WORD[8*idx_i[1:0] +: 8]) hit = RSN_BAD_ID;
    end else if (idx_i == I_VER) begin
      if (byte_i != VERSION) hit = RSN_BAD_VER;
    end else if (idx_i == I_UNITHI) begin
      if ({byte_i, units_lo_i} == 16'h0000) hit = RSN_ZERO_SIZE;
    end else if (idx_i == I_POFS0) begin
      if (byte_i[UNIT_LOG2-1:0] != '0) hit = RSN_MISALIGN;
    end else if (idx_i == I_POFS3) begin
      if ({byte_i, pofs_lo_i} < MIN_OFS) hit = RSN_SMALL_OFS;
    end
  end

  assign en = start_i | accept_i;

  always_comb begin
    fail_d   = fail_q;
    reason_d = reason_q;
    done_d   = done_q;
    if (start_i) begin
      fail_d   = 1'b0;
      reason_d = RSN_NONE;
      done_d   = 1'b0;
    end else if (accept_i) begin
      if (!fail_q && hit != RSN_NONE) begin
        fail_d   = 1'b1;
        reason_d = hit;
      end
      if (last_i) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q   <= 1'b0;
      reason_q <= RSN_NONE;
      done_q   <= 1'b0;
    end else if (en) begin
      fail_q   <= fail_d;
      reason_q <= reason_d;
      done_q   <= done_d;
    end
  end

  assign done_o   = done_q;
  assign pass_o   = done_q & ~fail_q;
  assign reason_o = done_q ? reason_q : 3'd0;

endmodule

// File: rtl/boot_hdr_validator.sv
module boot_hdr_validator
  import boot_hdr_pkg::*;
#(
  parameter int unsigned HDR_BYTES = 320,
  parameter int unsigned UNIT_LOG2 = 7,
  parameter logic [7:0]  VERSION   = 8'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  output logic        done_o,
  output logic        pass_o,
  output logic [2:0]  reason_o,
  output logic [31:0] load_addr_o,
  output logic [31:0] entry_addr_o,
  output logic [15:0] payload_units_o,
  output logic [31:0] payload_ofs_o,
  output logic [7:0]  spi_cfg_o,
  output logic [7:0]  ldr_flags_o,
  output logic [7:0]  read_cmd_o,
  output logic        fast_clk_o,
  output logic        auth_en_o,
  output logic        encrypted_o,
  output logic        flags_fixed_ok_o
);

  localparam int unsigned IDX_W = $clog2(HDR_BYTES);

  logic             accept;
  logic             last;
  logic [IDX_W-1:0] idx;

  boot_hdr_seq #(.HDR_BYTES(HDR_BYTES), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vld_i(byte_vld_i),
    .accept_o(accept), .last_o(last), .idx_o(idx)
  );

  boot_hdr_lefield #(.BASE(POS_LOAD), .NBYTES(4), .IDX_W(IDX_W)) u_load (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .accept_i(accept),
    .idx_i(idx), .byte_i(byte_i), .value_o(load_addr_o)
  );

  boot_hdr_lefield #(.BASE(POS_ENTRY), .NBYTES(4), .IDX_W(IDX_W)) u_entry (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .accept_i(accept),
    .idx_i(idx), .byte_i(byte_i), .value_o(entry_addr_o)
  );

  boot_hdr_lefield #(.BASE(POS_UNITS), .NBYTES(2), .IDX_W(IDX_W)) u_units (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .accept_i(accept),
    .idx_i(idx), .byte_i(byte_i), .value_o(payload_units_o)
  );

  boot_hdr_lefield #(.BASE(POS_POFS), .NBYTES(4), .IDX_W(IDX_W)) u_pofs (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .accept_i(accept),
    .idx_i(idx), .byte_i(byte_i), .value_o(payload_ofs_o)
  );

  boot_hdr_lefield #(.BASE(POS_SPI), .NBYTES(1), .IDX_W(IDX_W)) u_spi (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .accept_i(accept),
    .idx_i(idx), .byte_i(byte_i), .value_o(spi_cfg_o)
  );

  boot_hdr_lefield #(.BASE(POS_FLAGS), .NBYTES(1), .IDX_W(IDX_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .accept_i(accept),
    .idx_i(idx), .byte_i(byte_i), .value_o(ldr_flags_o)
  );

  boot_hdr_lefield #(.BASE(POS_RCMD), .NBYTES(1), .IDX_W(IDX_W)) u_rcmd (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .accept_i(accept),
    .idx_i(idx), .byte_i(byte_i), .value_o(read_cmd_o)
  );

  boot_hdr_judge #(
    .HDR_BYTES(HDR_BYTES), .UNIT_LOG2(UNIT_LOG2), .VERSION(VERSION), .IDX_W(IDX_W)
  ) u_judge (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .accept_i(accept),
    .last_i(last), .idx_i(idx), .byte_i(byte_i),
    .units_lo_i(payload_units_o[7:0]), .pofs_lo_i(payload_ofs_o[23:0]),
    .done_o(done_o), .pass_o(pass_o), .reason_o(reason_o)
  );

  assign fast_clk_o       = ldr_flags_o[0];
  assign auth_en_o        = ldr_flags_o[6];
  assign encrypted_o      = ldr_flags_o[7];
  assign flags_fixed_ok_o = (ldr_flags_o[5:3] == 3'b111);

endmodule

// File: rtl/boot_hdr_checker.sv
module boot_hdr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        done_o,
  input logic        pass_o,
  input logic [2:0]  reason_o,
  input logic [31:0] load_addr_o,
  input logic [31:0] entry_addr_o,
  input logic [15:0] payload_units_o,
  input logic [31:0] payload_ofs_o
);

  // R3
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o);

  // R12
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o && reason_o == 3'd0 && load_addr_o == 32'h0);

  // R9
  verdict_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pass_o == (reason_o == 3'd0)));

  // R9
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> done_o);

  // R4
  reason_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reason_o <= 3'd5);

  // R13
  fields_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> $stable(load_addr_o) && $stable(entry_addr_o)
      && $stable(payload_units_o) && $stable(payload_ofs_o) && $stable(reason_o));

endmodule

bind boot_hdr_validator boot_hdr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
  .pass_o(pass_o), .reason_o(reason_o), .load_addr_o(load_addr_o),
  .entry_addr_o(entry_addr_o), .payload_units_o(payload_units_o),
  .payload_ofs_o(payload_ofs_o)
);

// File: tb/tb_boot_hdr_validator.sv
`timescale 1ns/1ps
module tb_boot_hdr_validator;

  logic        clk, rst_n, start_i, byte_vld_i;
  logic [7:0]  byte_i;
  logic        done_o, pass_o;
  logic [2:0]  reason_o;
  logic [31:0] load_addr_o, entry_addr_o, payload_ofs_o;
  logic [15:0] payload_units_o;
  logic [7:0]  spi_cfg_o, ldr_flags_o, read_cmd_o;
  logic        fast_clk_o, auth_en_o, encrypted_o, flags_fixed_ok_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] hdr [0:319];

  boot_hdr_validator dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .done_o(done_o), .pass_o(pass_o), .reason_o(reason_o),
    .load_addr_o(load_addr_o), .entry_addr_o(entry_addr_o),
    .payload_units_o(payload_units_o), .payload_ofs_o(payload_ofs_o),
    .spi_cfg_o(spi_cfg_o), .ldr_flags_o(ldr_flags_o), .read_cmd_o(read_cmd_o),
    .fast_clk_o(fast_clk_o), .auth_en_o(auth_en_o), .encrypted_o(encrypted_o),
    .flags_fixed_ok_o(flags_fixed_ok_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put32(input int base, input logic [31:0] v);
    for (int k = 0; k < 4; k++) hdr[base + k] = v[8*k +: 8];
  endtask

  task automatic build_good();
    for (int i = 0; i < 320; i++) hdr[i] = 8'(i * 7 + 1);
    hdr[0] = 8'h50; hdr[1] = 8'h48; hdr[2] = 8'h43; hdr[3] = 8'h4D;
    hdr[4] = 8'h03; hdr[5] = 8'h25; hdr[6] = 8'h79; hdr[7] = 8'h01;
    put32(8, 32'h000C_0000);
    put32(12, 32'h000C_1235);
    hdr[16] = 8'h23; hdr[17] = 8'h01;
    put32(20, 32'h0000_1000);
  endtask

  task automatic send(input int gap_every, input int upto, input logic vld_on_start);
    @(negedge clk);
    start_i = 1'b1; byte_vld_i = vld_on_start; byte_i = 8'hAA;
    @(negedge clk);
    start_i = 1'b0; byte_vld_i = 1'b0;
    for (int i = 0; i < upto; i++) begin
      byte_vld_i = 1'b1; byte_i = hdr[i];
      @(negedge clk);
      byte_vld_i = 1'b0;
      if (gap_every > 0 && (i % gap_every) == 0) @(negedge clk);
    end
  endtask

  task automatic expect_reason(input string req, input logic [2:0] exp);
    chk({req, " done"}, 32'(done_o), 32'd1);
    chk({req, " reason"}, 32'(reason_o), 32'(exp));
    chk({req, " pass"}, 32'(pass_o), 32'(exp == 3'd0));
  endtask

  task automatic t_reset();
    chk("R1 done", 32'(done_o), 0);
    chk("R1 pass", 32'(pass_o), 0);
    chk("R1 reason", 32'(reason_o), 0);
    chk("R1 load", load_addr_o, 0);
    chk("R1 ofs", payload_ofs_o, 0);
  endtask

  task automatic t_good();
    build_good();
    send(5, 320, 1'b1);  // R2: strobe with start is ignored, gaps ignored
    expect_reason("R2 R3 good", 3'd0);
    chk("R10 load", load_addr_o, 32'h000C_0000);
    chk("R10 entry", entry_addr_o, 32'h000C_1235);
    chk("R10 units", 32'(payload_units_o), 32'h0123);
    chk("R10 ofs", payload_ofs_o, 32'h1000);
    chk("R11 spi", 32'(spi_cfg_o), 32'h25);
    chk("R11 flags", 32'(ldr_flags_o), 32'h79);
    chk("R11 rcmd", 32'(read_cmd_o), 32'h01);
    chk("R11 fast", 32'(fast_clk_o), 1);
    chk("R11 auth", 32'(auth_en_o), 1);
    chk("R11 encr", 32'(encrypted_o), 0);
    chk("R11 fixed", 32'(flags_fixed_ok_o), 1);
  endtask

  task automatic t_after_done();
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); byte_vld_i = 1'b1; byte_i = 8'hEE;
    end
    @(negedge clk); byte_vld_i = 1'b0;
    chk("R13 load", load_addr_o, 32'h000C_0000);
    chk("R13 ofs", payload_ofs_o, 32'h1000);
    expect_reason("R13 verdict", 3'd0);
  endtask

  task automatic t_flags_other();
    build_good(); hdr[6] = 8'h81;
    send(0, 320, 1'b0);
    expect_reason("R11 flags no verdict effect", 3'd0);
    chk("R11 fixed bad", 32'(flags_fixed_ok_o), 0);
    chk("R11 encr set", 32'(encrypted_o), 1);
    chk("R11 auth clr", 32'(auth_en_o), 0);
  endtask

  task automatic t_single_faults();
    build_good(); hdr[2] = 8'h00; send(0, 320, 1'b0);
    expect_reason("R4 id", 3'd1);
    build_good(); hdr[4] = 8'h02; send(0, 320, 1'b0);
    expect_reason("R5 ver", 3'd2);
    build_good(); hdr[16] = 8'h00; hdr[17] = 8'h00; send(0, 320, 1'b0);
    expect_reason("R6 zero", 3'd3);
    build_good(); hdr[16] = 8'h00; hdr[17] = 8'h01; send(0, 320, 1'b0);
    expect_reason("R6 high byte only", 3'd0);
    build_good(); put32(20, 32'h141); send(0, 320, 1'b0);
    expect_reason("R7 misalign", 3'd4);
    build_good(); put32(20, 32'h100); send(0, 320, 1'b0);
    expect_reason("R8 small", 3'd5);
    build_good(); put32(20, 32'h180); send(0, 320, 1'b0);
    expect_reason("R8 min legal", 3'd0);
    build_good(); put32(20, 32'h0100_0000); send(0, 320, 1'b0);
    expect_reason("R8 top byte", 3'd0);
    chk("R10 ofs top", payload_ofs_o, 32'h0100_0000);
  endtask

  task automatic t_first_fail();
    build_good(); hdr[0] = 8'h00; hdr[4] = 8'h09; hdr[16] = 0; hdr[17] = 0;
    send(0, 320, 1'b0);
    expect_reason("R9 id first", 3'd1);
    build_good(); hdr[4] = 8'h09; put32(20, 32'h80); send(0, 320, 1'b0);
    expect_reason("R9 ver first", 3'd2);
    build_good(); hdr[16] = 0; hdr[17] = 0; put32(20, 32'h41); send(0, 320, 1'b0);
    expect_reason("R9 zero first", 3'd3);
  endtask

  task automatic t_restart();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R12 done cleared", 32'(done_o), 0);
    chk("R12 reason cleared", 32'(reason_o), 0);
    chk("R12 ofs cleared", payload_ofs_o, 0);
    build_good(); hdr[1] = 8'h11;
    send(0, 100, 1'b0);
    chk("R3 not done mid", 32'(done_o), 0);
    build_good();
    send(3, 320, 1'b0);
    expect_reason("R12 restart good", 3'd0);
    chk("R12 entry", entry_addr_o, 32'h000C_1235);
  endtask

  task automatic t_no_header();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    build_good(); send(0, 320, 1'b0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); byte_vld_i = 1'b1; byte_i = 8'h00;
    end
    @(negedge clk); byte_vld_i = 1'b0;
    chk("R2 closed header ignores bytes", 32'(done_o), 1);
    chk("R2 closed header pass", 32'(pass_o), 1);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; byte_vld_i = 1'b0; byte_i = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_after_done();
    t_flags_other();
    t_single_faults();
    t_first_fail();
    t_restart();
    t_no_header();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule